// File: doc/BRIEF.md
# Cache Prefetch Hint Dispatcher

This block takes prefetch hints and turns each one into a line-fill command, or into nothing. A request carries a byte address, a two-bit locality hint, a memory-type code, an address-legal flag, and the L1 and L2 lookup results for that address. The lookup results are presented alongside the request. The block rounds the address down to the start of its cache line. The hint decides which cache levels should receive the line. Any level that already holds the line, or that sits behind a level holding it, is left out. A request is dropped without any fault when it is useless, illegal or aimed at uncacheable memory.

There is one request slot. An accepted request is evaluated in the next cycle. The block then either presents a fill on the output handshake, holding it until the fill port is ready, or raises a one-cycle drop pulse. Arrays, memory fetch and replacement belong to neighbouring blocks.

Top module: `pf_dispatch`

## Requirements
- R1: Hint code 00 (non-temporal) targets L1 only. A fill for it never has `fill_to_l2` set, even when the line misses L2.
- R2: Hint code 01 (keep in all levels) targets L1 and L2. If both miss, one fill is issued with both flags set. If L1 misses and L2 hits, only `fill_to_l1` is set.
- R3: Hint codes 10 and 11 both target L2 only and behave identically. A fill for them never has `fill_to_l1` set.
- R4: `fill_addr` equals the request address with its low log2(LINE_BYTES) bits cleared. With 32-byte lines these are bits [4:0]. Any unaligned address is accepted and maps to exactly one line.
- R5: A level gets no fill when the line is already in that level or in a level closer to the core. An L1 hit suppresses every fill. An L2 hit suppresses only the L2 target. When no target remains, the request is dropped.
- R6: Memory-type codes 00 (write-back) and 01 (write-through) are cacheable. Codes 10 (write-combining) and 11 (uncached, for example frame buffer space) make the request complete as a drop with no fill.
- R7: A request with `req_legal` low is dropped with no fill, and the block has no fault output.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the cycle after that edge, either `fill_valid` or `drop_pulse` is high, never both. `drop_pulse` lasts exactly one cycle.
- R9: While `fill_valid` is high and `fill_ready` is low, the fill address and flags stay stable. `req_ready` stays low for as long as an accepted request is outstanding.
- R10: During and after reset, `req_ready` is 1, `fill_valid` is 0 and `drop_pulse` is 0. A reset abandons any outstanding fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Prefetch request present |
| req_ready | output | 1 | Request slot free |
| req_addr | input | ADDR_W | Byte address of the prefetch |
| req_hint | input | 2 | Locality hint code |
| req_memtype | input | 2 | Memory-type code of the address |
| req_legal | input | 1 | Address is legal |
| req_l1_hit | input | 1 | Line present in L1 |
| req_l2_hit | input | 1 | Line present in L2 |
| fill_valid | output | 1 | Fill command present |
| fill_ready | input | 1 | Fill port accepts the command |
| fill_addr | output | ADDR_W | Line-aligned fill address |
| fill_to_l1 | output | 1 | Allocate the line in L1 |
| fill_to_l2 | output | 1 | Allocate the line in L2 |
| drop_pulse | output | 1 | Accepted request finished with no fill |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and 32-byte lines. It therefore exercises the rounding at both ends of the address space, including an all-ones address and an address at the last byte of a line. The bench covers every combination of the four hints, four memory types, the legal flag and the two hit flags. These combinations include the non-temporal hint with a lone L2 hit and the all-levels hint with a lone L2 hit. The bench stalls the fill port for zero to three cycles to hold commands in place, and it resets the block in the middle of a stall.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [1:0] {
    HINT_NTA = 2'b00,
    HINT_ALL = 2'b01,
    HINT_MID = 2'b10,
    HINT_OUT = 2'b11
  } hint_e;

  typedef enum logic [1:0] {
    MT_WBACK = 2'b00,
    MT_WTHRU = 2'b01,
    MT_WCOMB = 2'b10,
    MT_UNCAC = 2'b11
  } mtype_e;

  typedef struct packed {
    hint_e  hint;
    mtype_e mtype;
    logic   legal;
    logic   l1_hit;
    logic   l2_hit;
  } pf_attr_t;

  // Level targeting of a hint
  function automatic logic hint_wants_l1(hint_e h);
    return (h == HINT_NTA) || (h == HINT_ALL);
  endfunction

  function automatic logic hint_wants_l2(hint_e h);
    return (h == HINT_ALL) || (h == HINT_MID) || (h == HINT_OUT);
  endfunction

  function automatic logic mtype_cacheable(mtype_e m);
    return (m == MT_WBACK) || (m == MT_WTHRU);
  endfunction

endpackage

// File: rtl/pf_intake.sv
module pf_intake
  import pf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  pf_attr_t          attr_i,
  input  logic              release_i,
  output logic              held_o,
  output logic [ADDR_W-1:0] addr_o,
  output pf_attr_t          attr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o <= 1'b0;
      addr_o <= '0;
      attr_o <= '0;
    end else if (take_i) begin
      held_o <= 1'b1;
      addr_o <= addr_i;
      attr_o <= attr_i;
    end else if (release_i) begin
      held_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pf_decide.sv
module pf_decide
  import pf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  pf_attr_t          attr_i,
  output logic              want_fill_o,
  output logic              tgt_l1_o,
  output logic              tgt_l2_o,
  output logic [ADDR_W-1:0] line_addr_o
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

  logic allowed;

  always_comb begin
    allowed  = attr_i.legal && mtype_cacheable(attr_i.mtype);
    // A hit in L1 covers every target. A hit in L2 covers only the L2 target.
    tgt_l1_o = hint_wants_l1(attr_i.hint) && !attr_i.l1_hit;
    tgt_l2_o = hint_wants_l2(attr_i.hint) && !attr_i.l1_hit && !attr_i.l2_hit;
    want_fill_o = allowed && (tgt_l1_o || tgt_l2_o);
    line_addr_o = addr_i & ~OFF_MASK;
  end

endmodule

// File: rtl/pf_issue.sv
module pf_issue (
  input  logic held_i,
  input  logic want_fill_i,
  input  logic fill_ready_i,
  output logic fill_valid_o,
  output logic drop_o,
  output logic release_o
);

  always_comb begin
    fill_valid_o = held_i && want_fill_i;
    drop_o       = held_i && !want_fill_i;
    release_o    = drop_o || (fill_valid_o && fill_ready_i);
  end

endmodule

// File: rtl/pf_dispatch.sv
module pf_dispatch
  import pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_hint,
  input  logic [1:0]        req_memtype,
  input  logic              req_legal,
  input  logic              req_l1_hit,
  input  logic              req_l2_hit,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_to_l1,
  output logic              fill_to_l2,
  output logic              drop_pulse
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  pf_attr_t          in_attr;
  pf_attr_t          cur_attr;
  logic [ADDR_W-1:0] cur_addr;
  logic              pend;
  logic              take;
  logic              release_slot;
  logic              want_fill;
  logic [1:0]        cur_hint;

  always_comb begin
    in_attr.hint   = hint_e'(req_hint);
    in_attr.mtype  = mtype_e'(req_memtype);
    in_attr.legal  = req_legal;
    in_attr.l1_hit = req_l1_hit;
    in_attr.l2_hit = req_l2_hit;
    req_ready      = !pend;
    take           = req_valid && req_ready;
    cur_hint       = cur_attr.hint;
  end

  pf_intake #(.ADDR_W(ADDR_W)) u_intake (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take),
    .addr_i    (req_addr),
    .attr_i    (in_attr),
    .release_i (release_slot),
    .held_o    (pend),
    .addr_o    (cur_addr),
    .attr_o    (cur_attr)
  );

  pf_decide #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_decide (
    .addr_i      (cur_addr),
    .attr_i      (cur_attr),
    .want_fill_o (want_fill),
    .tgt_l1_o    (fill_to_l1),
    .tgt_l2_o    (fill_to_l2),
    .line_addr_o (fill_addr)
  );

  pf_issue u_issue (
    .held_i       (pend),
    .want_fill_i  (want_fill),
    .fill_ready_i (fill_ready),
    .fill_valid_o (fill_valid),
    .drop_o       (drop_pulse),
    .release_o    (release_slot)
  );

endmodule

// File: rtl/pf_dispatch_chk.sv
module pf_dispatch_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              fill_to_l1,
  input logic              fill_to_l2,
  input logic              drop_pulse,
  input logic              pend,
  input logic [1:0]        cur_hint
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  p_nta_l1only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && cur_hint == 2'b00) |-> !fill_to_l2);

  p_mid_l2only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && cur_hint[1]) |-> !fill_to_l1);

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_addr[OFF_W-1:0] == '0));

  p_some_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_to_l1 || fill_to_l2));

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && drop_pulse));

  p_drop_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> (!drop_pulse && req_ready));

  p_outcome_when_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (fill_valid || drop_pulse));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=>
      (fill_valid && $stable(fill_addr) && $stable(fill_to_l1) && $stable(fill_to_l2)));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_ready);

endmodule

bind pf_dispatch pf_dispatch_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/sim_pf_dispatch.sv
module sim_pf_dispatch;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NTBL = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_hint = '0;
  logic [1:0]    req_memtype = '0;
  logic          req_legal = 1'b0;
  logic          req_l1_hit = 1'b0;
  logic          req_l2_hit = 1'b0;
  logic          fill_valid;
  logic          fill_ready = 1'b0;
  logic [AW-1:0] fill_addr;
  logic          fill_to_l1;
  logic          fill_to_l2;
  logic          drop_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_dispatch #(.ADDR_W(AW), .LINE_BYTES(32)) u0 (.*);

  // {hint, memtype, legal, l1, l2, addr, exp_fill, exp_l1, exp_l2}
  localparam logic [41:0] TBL [NTBL] = '{
    {2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 32'h1000_0013, 1'b1, 1'b1, 1'b0}, // R1
    {2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 32'h2000_0044, 1'b1, 1'b1, 1'b0}, // R1 R5
    {2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 32'h3000_0021, 1'b1, 1'b1, 1'b1}, // R2
    {2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 32'h3000_0107, 1'b1, 1'b1, 1'b0}, // R2
    {2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 32'h4000_0000, 1'b0, 1'b0, 1'b0}, // R5
    {2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 32'h5000_003C, 1'b1, 1'b0, 1'b1}, // R3
    {2'b11, 2'b01, 1'b1, 1'b0, 1'b0, 32'h5000_003C, 1'b1, 1'b0, 1'b1}, // R3
    {2'b10, 2'b00, 1'b1, 1'b0, 1'b1, 32'h6000_0001, 1'b0, 1'b0, 1'b0}, // R5
    {2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 32'h6000_0002, 1'b0, 1'b0, 1'b0}, // R5
    {2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 32'h7000_0000, 1'b0, 1'b0, 1'b0}, // R6
    {2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 32'h7000_0020, 1'b0, 1'b0, 1'b0}, // R6
    {2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b0}, // R7
    {2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1}, // R4
    {2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 32'h0000_001F, 1'b1, 1'b1, 1'b0}  // R4
  };

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench reference model of the level choice
  function automatic logic [2:0] model(input logic [1:0] h, input logic [1:0] mt,
                                       input logic lg, input logic h1, input logic h2);
    logic a1, a2, e1, e2, ok;
    case (h)
      2'b00:   begin a1 = 1'b1; a2 = 1'b0; end
      2'b01:   begin a1 = 1'b1; a2 = 1'b1; end
      default: begin a1 = 1'b0; a2 = 1'b1; end
    endcase
    e1 = a1 & ~h1;
    e2 = a2 & ~(h1 | h2);
    ok = lg & ~mt[1];
    return {ok & (e1 | e2), e1, e2};
  endfunction

  task automatic send(input logic [1:0] h, input logic [1:0] mt, input logic lg,
                      input logic h1, input logic h2, input logic [AW-1:0] a,
                      input logic [2:0] ex, input int stall, input string tag);
    logic [AW-1:0] line;
    line = a & ~32'h1F;
    @(negedge clk);
    chk(req_ready === 1'b1, {tag, " R9 ready before send"}, AW'(req_ready), 1);
    req_valid = 1'b1; req_hint = h; req_memtype = mt; req_legal = lg;
    req_l1_hit = h1; req_l2_hit = h2; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (ex[2]) begin
      chk(fill_valid === 1'b1 && drop_pulse === 1'b0, {tag, " R8 fill issued"},
          AW'({fill_valid, drop_pulse}), 2);
      chk(fill_addr === line, {tag, " R4 line address"}, fill_addr, line);
      chk({fill_to_l1, fill_to_l2} === ex[1:0], {tag, " R1 R2 R3 R5 targets"},
          AW'({fill_to_l1, fill_to_l2}), AW'(ex[1:0]));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(fill_valid === 1'b1 && fill_addr === line && {fill_to_l1, fill_to_l2} === ex[1:0],
            {tag, " R9 held under stall"}, fill_addr, line);
        chk(req_ready === 1'b0, {tag, " R9 busy"}, AW'(req_ready), 0);
      end
      fill_ready = 1'b1;
      @(negedge clk);
      fill_ready = 1'b0;
      chk(fill_valid === 1'b0 && req_ready === 1'b1, {tag, " R8 released"},
          AW'({fill_valid, req_ready}), 1);
    end else begin
      chk(drop_pulse === 1'b1 && fill_valid === 1'b0, {tag, " R5 R6 R7 R8 dropped"},
          AW'({fill_valid, drop_pulse}), 1);
      @(negedge clk);
      chk(drop_pulse === 1'b0 && req_ready === 1'b1, {tag, " R8 single drop pulse"},
          AW'({drop_pulse, req_ready}), 1);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && fill_valid === 1'b0 && drop_pulse === 1'b0,
        "R10 values in reset", AW'({req_ready, fill_valid, drop_pulse}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && fill_valid === 1'b0 && drop_pulse === 1'b0,
        "R10 values after reset", AW'({req_ready, fill_valid, drop_pulse}), 4);

    for (int i = 0; i < NTBL; i++) begin
      logic [41:0] e;
      e = TBL[i];
      send(e[41:40], e[39:38], e[37], e[36], e[35], e[34:3], e[2:0], i % 3, "table");
    end

    // R3: both mid-level codes give identical results for every hit pattern
    for (int k = 0; k < 4; k++) begin
      logic [2:0] ex;
      ex = model(2'b10, 2'b00, 1'b1, k[1], k[0]);
      send(2'b10, 2'b00, 1'b1, k[1], k[0], 32'h0ABC_0000 + k, ex, 0, "R3 code10");
      send(2'b11, 2'b00, 1'b1, k[1], k[0], 32'h0ABC_0000 + k, ex, 0, "R3 code11");
    end

    for (int i = 0; i < 300; i++) begin
      logic [1:0] h, mt;
      logic lg, h1, h2;
      logic [AW-1:0] a;
      h = 2'($urandom); mt = 2'($urandom); lg = ($urandom % 4) != 0;
      h1 = ($urandom % 3) == 0; h2 = ($urandom % 3) == 0; a = $urandom;
      send(h, mt, lg, h1, h2, a, model(h, mt, lg, h1, h2), i % 4, "random");
    end

    // R10: a reset during a stalled fill abandons it
    @(negedge clk);
    req_valid = 1'b1; req_hint = 2'b01; req_memtype = 2'b00; req_legal = 1'b1;
    req_l1_hit = 1'b0; req_l2_hit = 1'b0; req_addr = 32'h1234_5678;
    @(negedge clk);
    req_valid = 1'b0;
    chk(fill_valid === 1'b1, "R10 fill pending before reset", AW'(fill_valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(fill_valid === 1'b0 && req_ready === 1'b1 && drop_pulse === 1'b0,
        "R10 fill abandoned by reset", AW'({fill_valid, req_ready, drop_pulse}), 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(fill_valid === 1'b0 && drop_pulse === 1'b0, "R10 quiet after reset",
        AW'({fill_valid, drop_pulse}), 0);

    finish_run();
  end

endmodule